// File: doc/BRIEF.md
# VGA-compatible I/O register port emulator

This block is a byte-wide I/O slave that stands in for the legacy colour-graphics register ports. A host, such as a firmware interpreter that runs video option code, issues reads and writes to a port offset. The block keeps the register state that such code expects to find there.

The state it keeps:
- an attribute register array, reached through a single shared port whose role alternates between index and data;
- indexed register files for the sequencer, graphics controller and CRT controller;
- a miscellaneous output register and a pixel mask register;
- a palette RAM with auto-stepping read and write pointers;
- a status register whose retrace bits flip on every read.

Video timing, display memory and pixel output are not part of it.

The address input is the port number minus 0x3C0, so offset 0x1A is port 0x3DA. Read data is registered. A 16-bit write is split by the block into two byte writes on consecutive cycles.

Top module: `vga_port_emu`

## Requirements
- R1: After reset, every index register, both palette pointers, the miscellaneous register, the pixel mask, the status register, the attribute toggle and rdata_o are 0.
- R2: rdata_o changes only in the clock edge that samples rd_i high, and it holds otherwise. A read of an offset with no register returns 0xFF. The offsets with a register are 0x00, 0x01, 0x04–0x09, 0x0C, 0x0E, 0x0F, 0x14, 0x15 and 0x1A.
- R3: At offset 0x00, every read or write toggles the attribute toggle.
  - With the toggle at 0, a write sets the attribute index and a read returns it.
  - With the toggle at 1, a write stores to and a read returns the attribute register at that index.
  - A read of offset 0x01 returns the attribute register at the index and leaves the toggle unchanged.
  - Writes to 0x01 are ignored.
- R4: A read of offset 0x1A returns the status register, then XORs it with 0x09 and clears the attribute toggle.
- R5: A write to offset 0x07 or 0x08 loads the palette read or write pointer with three times the written byte. Reads of 0x07 and 0x08 return bits 7:0 of that pointer.
- R6: A read of offset 0x09 returns the palette entry at the read pointer and then advances the pointer. A write of 0x09 stores at the write pointer and then advances it. While a pointer is at 768 or more, its access does nothing and a read returns 0xFF.
- R7: Offsets 0x14 (CRTC index) and 0x15 (CRTC data) respond only while bit 0 of the miscellaneous register is 1. Otherwise writes are ignored and reads return 0xFF.
- R8: The miscellaneous register is written at offset 0x02 and read at 0x0C. A read of 0x02 returns 0xFF.
- R9: A data port (0x00 in its data role, 0x01, 0x05, 0x0F, 0x15) whose index is at or above its array size reads 0xFF and ignores writes. The sizes are 21 attribute, 5 sequencer, 9 graphics and 25 CRTC.
- R10: A write with wide_i set stores wdata_i[7:0] at addr_i in that cycle and wdata_i[15:8] at addr_i+1 in the next cycle. Any write strobe in that next cycle is ignored. A high byte aimed above 0x1A is dropped.
- R11: When a read and a write take effect in the same cycle, the read sees the state before the write, and the write then applies on top of the read's side effects.
- R12: The sequencer index (0x04), graphics index (0x0E) and pixel mask (0x06) are plain read/write registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Port offset from 0x3C0, shared by read and write |
| rd_i | input | 1 | Read strobe, one access per cycle high |
| wr_i | input | 1 | Write strobe |
| wide_i | input | 1 | Qualifies wr_i as a 16-bit write |
| wdata_i | input | 16 | Write data; the upper byte is used only by wide writes |
| rdata_o | output | 8 | Registered read data, valid the cycle after rd_i |

## Verification
A read and a write can take effect in the same cycle in two ways. The host can raise both strobes together on one offset, or a read can fall in the cycle in which the split high byte of a wide write is stored.

The bench provokes both. One case is a wide write at offset 0x08 with the palette read and write pointers equal, followed at once by a read of 0x09. The other is a combined read and write at 0x00 and 0x1A.

Each response is judged against a bench model that applies the read first and the write second.

// File: rtl/vga_port_pkg.sv
package vga_port_pkg;
  typedef logic [7:0] byte_t;

  // offsets from port 0x3C0
  localparam int unsigned OFS_ATTR     = 0;
  localparam int unsigned OFS_ATTR_RD  = 1;
  localparam int unsigned OFS_MISC_WR  = 2;
  localparam int unsigned OFS_SEQ_IDX  = 4;
  localparam int unsigned OFS_SEQ_DAT  = 5;
  localparam int unsigned OFS_PEL      = 6;
  localparam int unsigned OFS_DAC_RIDX = 7;
  localparam int unsigned OFS_DAC_WIDX = 8;
  localparam int unsigned OFS_DAC_DAT  = 9;
  localparam int unsigned OFS_MISC_RD  = 12;
  localparam int unsigned OFS_GFX_IDX  = 14;
  localparam int unsigned OFS_GFX_DAT  = 15;
  localparam int unsigned OFS_CRTC_IDX = 20;
  localparam int unsigned OFS_CRTC_DAT = 21;
  localparam int unsigned OFS_STATUS   = 26;

  localparam byte_t RD_NONE     = 8'hFF;
  localparam byte_t STATUS_FLIP = 8'h09;
endpackage

// File: rtl/vga_wide_split.sv
module vga_wide_split #(
  parameter int unsigned AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [15:0]       wdata_i,
  output logic              wr_o,
  output logic [AW:0]       addr_o,
  output logic [7:0]        wdata_o,
  output logic              pend_o
);
  logic          pend_q;
  logic [AW:0]   pend_addr_q;
  logic [7:0]    pend_data_q;
  logic          start;

  assign start = wr_i && wide_i && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_q <= start;
      if (start) begin
        pend_addr_q <= {1'b0, addr_i} + (AW+1)'(1);
        pend_data_q <= wdata_i[15:8];
      end
    end
  end

  // pending high byte owns the write path; a fresh strobe is dropped
  always_comb begin
    if (pend_q) begin
      wr_o    = 1'b1;
      addr_o  = pend_addr_q;
      wdata_o = pend_data_q;
    end else begin
      wr_o    = wr_i;
      addr_o  = {1'b0, addr_i};
      wdata_o = wdata_i[7:0];
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/vga_index_file.sv
module vga_index_file
  import vga_port_pkg::*;
#(
  parameter int unsigned DEPTH = 5
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  idx_we_i,
  input  logic  dat_we_i,
  input  byte_t wdata_i,
  output byte_t idx_o,
  output byte_t dat_o
);
  localparam int unsigned SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  byte_t idx_q;
  byte_t regs_q [DEPTH];
  logic  hit;

  assign hit = (32'(idx_q) < DEPTH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
    end else begin
      if (idx_we_i) idx_q <= wdata_i;
      if (dat_we_i && hit) regs_q[idx_q[SW-1:0]] <= wdata_i;
    end
  end

  assign idx_o = idx_q;
  assign dat_o = hit ? regs_q[idx_q[SW-1:0]] : RD_NONE;
endmodule

// File: rtl/vga_dac.sv
module vga_dac
  import vga_port_pkg::*;
#(
  parameter int unsigned PAL_N = 768,
  parameter int unsigned PTR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ridx_we_i,
  input  logic             widx_we_i,
  input  logic             dat_re_i,
  input  logic             dat_we_i,
  input  byte_t            wdata_i,
  output logic [PTR_W-1:0] rptr_o,
  output logic [PTR_W-1:0] wptr_o,
  output byte_t            dat_o
);
  logic [PTR_W-1:0] rptr_q, wptr_q, load_val;
  logic             rhit, whit;
  byte_t            pal_q [PAL_N];

  assign rhit     = (32'(rptr_q) < PAL_N);
  assign whit     = (32'(wptr_q) < PAL_N);
  assign load_val = PTR_W'(32'(wdata_i) * 32'd3);

  // index load wins over the auto-step of the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q <= '0;
      wptr_q <= '0;
    end else begin
      if (ridx_we_i)            rptr_q <= load_val;
      else if (dat_re_i && rhit) rptr_q <= rptr_q + PTR_W'(1);
      if (widx_we_i)            wptr_q <= load_val;
      else if (dat_we_i && whit) wptr_q <= wptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (dat_we_i && whit) pal_q[wptr_q] <= wdata_i;
  end

  assign rptr_o = rptr_q;
  assign wptr_o = wptr_q;
  assign dat_o  = rhit ? pal_q[rptr_q] : RD_NONE;
endmodule

// File: rtl/vga_port_emu.sv
module vga_port_emu
  import vga_port_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned ATTR_N = 21,
  parameter int unsigned SEQ_N  = 5,
  parameter int unsigned GFX_N  = 9,
  parameter int unsigned CRTC_N = 25,
  parameter int unsigned PAL_N  = 768,
  parameter int unsigned PTR_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              wide_i,
  input  logic [15:0]       wdata_i,
  output logic [7:0]        rdata_o
);
  logic              w_en, pend;
  logic [ADDR_W:0]   w_addr;
  byte_t             w_data;

  vga_wide_split #(.AW(ADDR_W)) u_split (
    .clk_i, .rst_ni, .wr_i, .wide_i, .addr_i, .wdata_i,
    .wr_o(w_en), .addr_o(w_addr), .wdata_o(w_data), .pend_o(pend)
  );

  function automatic logic w_at(input logic en, input logic [ADDR_W:0] a, input int unsigned ofs);
    return en && (32'(a) == ofs);
  endfunction

  logic wr_attr, wr_misc, wr_seq_i, wr_seq_d, wr_pel, wr_ridx, wr_widx, wr_dac;
  logic wr_gfx_i, wr_gfx_d, wr_crtc_i, wr_crtc_d;
  logic rd_attr, rd_status, rd_dac;

  assign wr_attr   = w_at(w_en, w_addr, OFS_ATTR);
  assign wr_misc   = w_at(w_en, w_addr, OFS_MISC_WR);
  assign wr_seq_i  = w_at(w_en, w_addr, OFS_SEQ_IDX);
  assign wr_seq_d  = w_at(w_en, w_addr, OFS_SEQ_DAT);
  assign wr_pel    = w_at(w_en, w_addr, OFS_PEL);
  assign wr_ridx   = w_at(w_en, w_addr, OFS_DAC_RIDX);
  assign wr_widx   = w_at(w_en, w_addr, OFS_DAC_WIDX);
  assign wr_dac    = w_at(w_en, w_addr, OFS_DAC_DAT);
  assign wr_gfx_i  = w_at(w_en, w_addr, OFS_GFX_IDX);
  assign wr_gfx_d  = w_at(w_en, w_addr, OFS_GFX_DAT);
  assign wr_crtc_i = w_at(w_en, w_addr, OFS_CRTC_IDX);
  assign wr_crtc_d = w_at(w_en, w_addr, OFS_CRTC_DAT);

  assign rd_attr   = rd_i && (32'(addr_i) == OFS_ATTR);
  assign rd_status = rd_i && (32'(addr_i) == OFS_STATUS);
  assign rd_dac    = rd_i && (32'(addr_i) == OFS_DAC_DAT);

  byte_t misc_q, pel_q, status_q, rdata_q;
  logic  ff_q, ff_mid;

  // read side effects first, then the write sees the result
  assign ff_mid = rd_status ? 1'b0 : (rd_attr ? ~ff_q : ff_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff_q     <= 1'b0;
      misc_q   <= '0;
      pel_q    <= '0;
      status_q <= '0;
    end else begin
      ff_q <= wr_attr ? ~ff_mid : ff_mid;
      if (wr_misc)   misc_q   <= w_data;
      if (wr_pel)    pel_q    <= w_data;
      if (rd_status) status_q <= status_q ^ STATUS_FLIP;
    end
  end

  byte_t attr_idx, attr_dat, seq_idx, seq_dat, gfx_idx, gfx_dat, crtc_idx, crtc_dat, dac_dat;
  logic [PTR_W-1:0] rptr, wptr;
  logic crtc_en;

  assign crtc_en = misc_q[0];

  vga_index_file #(.DEPTH(ATTR_N)) u_attr (
    .clk_i, .rst_ni,
    .idx_we_i(wr_attr && !ff_mid), .dat_we_i(wr_attr && ff_mid),
    .wdata_i(w_data), .idx_o(attr_idx), .dat_o(attr_dat)
  );
  vga_index_file #(.DEPTH(SEQ_N)) u_seq (
    .clk_i, .rst_ni, .idx_we_i(wr_seq_i), .dat_we_i(wr_seq_d),
    .wdata_i(w_data), .idx_o(seq_idx), .dat_o(seq_dat)
  );
  vga_index_file #(.DEPTH(GFX_N)) u_gfx (
    .clk_i, .rst_ni, .idx_we_i(wr_gfx_i), .dat_we_i(wr_gfx_d),
    .wdata_i(w_data), .idx_o(gfx_idx), .dat_o(gfx_dat)
  );
  vga_index_file #(.DEPTH(CRTC_N)) u_crtc (
    .clk_i, .rst_ni, .idx_we_i(wr_crtc_i && crtc_en), .dat_we_i(wr_crtc_d && crtc_en),
    .wdata_i(w_data), .idx_o(crtc_idx), .dat_o(crtc_dat)
  );

  vga_dac #(.PAL_N(PAL_N), .PTR_W(PTR_W)) u_dac (
    .clk_i, .rst_ni, .ridx_we_i(wr_ridx), .widx_we_i(wr_widx),
    .dat_re_i(rd_dac), .dat_we_i(wr_dac), .wdata_i(w_data),
    .rptr_o(rptr), .wptr_o(wptr), .dat_o(dac_dat)
  );

  byte_t rd_mux;
  always_comb begin
    case (32'(addr_i))
      OFS_ATTR:     rd_mux = ff_q ? attr_dat : attr_idx;
      OFS_ATTR_RD:  rd_mux = attr_dat;
      OFS_SEQ_IDX:  rd_mux = seq_idx;
      OFS_SEQ_DAT:  rd_mux = seq_dat;
      OFS_PEL:      rd_mux = pel_q;
      OFS_DAC_RIDX: rd_mux = rptr[7:0];
      OFS_DAC_WIDX: rd_mux = wptr[7:0];
      OFS_DAC_DAT:  rd_mux = dac_dat;
      OFS_MISC_RD:  rd_mux = misc_q;
      OFS_GFX_IDX:  rd_mux = gfx_idx;
      OFS_GFX_DAT:  rd_mux = gfx_dat;
      OFS_CRTC_IDX: rd_mux = crtc_en ? crtc_idx : RD_NONE;
      OFS_CRTC_DAT: rd_mux = crtc_en ? crtc_dat : RD_NONE;
      OFS_STATUS:   rd_mux = status_q;
      default:      rd_mux = RD_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/vga_port_chk.sv
module vga_port_chk #(
  parameter int unsigned AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] addr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic          wide_i,
  input logic [15:0]   wdata_i,
  input logic [7:0]    rdata_o,
  input logic          ff_q,
  input logic [7:0]    status_q,
  input logic [7:0]    misc_q,
  input logic          w_en,
  input logic [AW:0]   w_addr,
  input logic [7:0]    w_data,
  input logic          pend
);
  logic rd_at0, rd_st, wr_at0;
  assign rd_at0 = rd_i && (32'(addr_i) == 0);
  assign rd_st  = rd_i && (32'(addr_i) == 26);
  assign wr_at0 = w_en && (32'(w_addr) == 0);

  assert_rdata_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));

  assert_unmapped_ff_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (32'(addr_i) > 26) |=> rdata_o == 8'hFF);

  assert_attr_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_at0 && !rd_at0 && !rd_st |=> ff_q != $past(ff_q));

  assert_status_flip_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st |=> rdata_o == $past(status_q) && status_q == ($past(status_q) ^ 8'h09));

  assert_status_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st && !wr_at0 |=> !ff_q);

  assert_crtc_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (32'(addr_i) == 20) && !misc_q[0] |=> rdata_o == 8'hFF);

  assert_misc_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w_en && (32'(w_addr) == 2) |=> misc_q == $past(w_data));

  assert_wide_split_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wide_i && !pend |=> w_en && pend &&
      (32'(w_addr) == 32'($past(addr_i)) + 1) && (w_data == $past(wdata_i[15:8])));
endmodule

bind vga_port_emu vga_port_chk #(.AW(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
  .wide_i(wide_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .ff_q(ff_q),
  .status_q(status_q), .misc_q(misc_q), .w_en(w_en), .w_addr(w_addr),
  .w_data(w_data), .pend(pend)
);

// File: tb/tb_vga_port_emu.sv
module tb_vga_port_emu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0, wide_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [7:0]  rdata_o;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  vga_port_emu dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i),
    .wide_i(wide_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  // reference model
  logic       m_ff = 0;
  logic [7:0] m_aidx = 0, m_sidx = 0, m_gidx = 0, m_cidx = 0;
  logic [7:0] m_misc = 0, m_pel = 0, m_status = 0;
  logic [7:0] m_attr [21], m_seq [5], m_gfx [9], m_crtc [25], m_pal [768];
  int         m_rp = 0, m_wp = 0;
  logic       m_pend = 0;
  int         m_pend_a = 0;
  logic [7:0] m_pend_d = 0;

  function automatic logic [7:0] mread(input int a);
    logic [7:0] r = 8'hFF;
    case (a)
      0: begin r = m_ff ? ((m_aidx < 21) ? m_attr[m_aidx] : 8'hFF) : m_aidx; m_ff = ~m_ff; end
      1: r = (m_aidx < 21) ? m_attr[m_aidx] : 8'hFF;
      4: r = m_sidx;
      5: r = (m_sidx < 5) ? m_seq[m_sidx] : 8'hFF;
      6: r = m_pel;
      7: r = 8'(m_rp);
      8: r = 8'(m_wp);
      9: if (m_rp < 768) begin r = m_pal[m_rp]; m_rp++; end
      12: r = m_misc;
      14: r = m_gidx;
      15: r = (m_gidx < 9) ? m_gfx[m_gidx] : 8'hFF;
      20: r = m_misc[0] ? m_cidx : 8'hFF;
      21: r = (m_misc[0] && m_cidx < 25) ? m_crtc[m_cidx] : 8'hFF;
      26: begin r = m_status; m_status ^= 8'h09; m_ff = 0; end
      default: r = 8'hFF;
    endcase
    return r;
  endfunction

  function automatic void mwrite(input int a, input logic [7:0] d);
    case (a)
      0: begin
        if (!m_ff) m_aidx = d; else if (m_aidx < 21) m_attr[m_aidx] = d;
        m_ff = ~m_ff;
      end
      2: m_misc = d;
      4: m_sidx = d;
      5: if (m_sidx < 5) m_seq[m_sidx] = d;
      6: m_pel = d;
      7: m_rp = int'(d) * 3;
      8: m_wp = int'(d) * 3;
      9: if (m_wp < 768) begin m_pal[m_wp] = d; m_wp++; end
      14: m_gidx = d;
      15: if (m_gidx < 9) m_gfx[m_gidx] = d;
      20: if (m_misc[0]) m_cidx = d;
      21: if (m_misc[0] && m_cidx < 25) m_crtc[m_cidx] = d;
      default: ;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    case (a)
      0, 1: return "R3";
      26: return "R4";
      7, 8: return "R5";
      9: return "R6";
      20, 21: return "R7";
      2, 12: return "R8";
      5, 15: return "R9";
      4, 6, 14: return "R12";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, read result 1 ns after the rising edge
  task automatic step(input logic rd, input logic wr, input logic wide, input int a,
                      input logic [15:0] d, input string tag);
    logic [7:0] exp;
    exp = 8'hFF;
    @(negedge clk);
    rd_i = rd; wr_i = wr; wide_i = wide; addr_i = 5'(a); wdata_i = d;
    if (rd) exp = mread(a);
    if (m_pend) begin
      mwrite(m_pend_a, m_pend_d);
      m_pend = 0;
    end else if (wr) begin
      mwrite(a, d[7:0]);
      if (wide) begin m_pend = 1; m_pend_a = a + 1; m_pend_d = d[15:8]; end
    end
    @(posedge clk);
    #1;
    rd_i = 0; wr_i = 0; wide_i = 0;
    if (rd) check((tag == "") ? tag_of(a) : tag, rdata_o, exp);
  endtask

  task automatic wr8(input int a, input logic [7:0] d);
    step(0, 1, 0, a, {8'h00, d}, "");
  endtask
  task automatic rd8(input int a, input string tag);
    step(1, 0, 0, a, 16'h0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  localparam int HOT [15] = '{0, 1, 2, 4, 5, 6, 7, 8, 9, 12, 14, 15, 20, 21, 26};

  initial begin
    for (int i = 0; i < 21; i++) m_attr[i] = 0;
    for (int i = 0; i < 5; i++)  m_seq[i] = 0;
    for (int i = 0; i < 9; i++)  m_gfx[i] = 0;
    for (int i = 0; i < 25; i++) m_crtc[i] = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", rdata_o, 8'h00);
    rd8(26, "R1"); rd8(12, "R1"); rd8(7, "R1"); rd8(8, "R1"); rd8(6, "R1");
    rd8(4, "R1"); rd8(14, "R1"); rd8(0, "R1");
    rd8(26, "R4");

    // palette fill, then pointer guards
    wr8(8, 8'd0);
    for (int i = 0; i < 768; i++) wr8(9, 8'((i * 7 + 3) & 255));
    rd8(8, "R6");
    wr8(9, 8'h5C);
    rd8(8, "R6");
    wr8(7, 8'd255);
    rd8(7, "R5");
    for (int i = 0; i < 4; i++) rd8(9, "R6");
    wr8(7, 8'd2); rd8(9, "R6"); rd8(7, "R5");

    // misc and CRTC gating
    wr8(2, 8'h00); wr8(20, 8'd3); wr8(21, 8'hAA);
    rd8(20, "R7"); rd8(21, "R7"); rd8(2, "R8");
    wr8(2, 8'h01); rd8(12, "R8"); rd8(20, "R7");
    wr8(20, 8'd3); wr8(21, 8'hAA); rd8(21, "R7");
    wr8(20, 8'd30); rd8(21, "R9");

    // attribute toggle
    rd8(26, "R4");
    wr8(0, 8'd5); wr8(0, 8'h5A); rd8(1, "R3"); rd8(0, "R3"); rd8(0, "R3");
    wr8(1, 8'h11); rd8(1, "R3");
    rd8(26, "R4"); wr8(0, 8'd25); wr8(0, 8'h33); rd8(0, "R9"); rd8(0, "R9");
    rd8(26, "R4"); rd8(26, "R4"); rd8(26, "R4");

    // wide writes
    step(0, 1, 1, 4, 16'hC302, "");
    rd8(4, "R10"); rd8(5, "R10");
    step(0, 1, 1, 14, 16'h9907, "");
    step(0, 1, 0, 6, 16'h0044, "");
    rd8(15, "R10"); rd8(6, "R10");
    step(0, 1, 1, 25, 16'hEE01, "");
    rd8(26, "R10");

    // same-cycle read and write
    wr8(7, 8'd10);
    step(0, 1, 1, 8, 16'h770A, "");
    step(1, 0, 0, 9, 16'h0, "R11");
    wr8(7, 8'd10); rd8(9, "R11");
    rd8(26, "R11");
    step(1, 1, 0, 0, 16'h0003, "R11");
    step(1, 1, 0, 0, 16'h0042, "R11");
    rd8(1, "R11");
    step(1, 1, 0, 26, 16'h00FF, "R11");
    rd8(0, "R11");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int a;
      logic rd, wr, wide;
      a    = ($urandom % 5 != 0) ? HOT[$urandom % 15] : int'($urandom % 32);
      rd   = ($urandom % 2) == 1;
      wr   = ($urandom % 3) == 0;
      wide = wr && (($urandom % 6) == 0);
      step(rd, wr, wide, a, 16'($urandom), "");
    end
    step(0, 0, 0, 0, 16'h0, "");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule